// File: doc/BRIEF.md
# Command-Driven 32-bit NOR Flash Bank Model

This block is a synthesizable device-side model of a 32-bit NOR flash bank built from two 16-bit halves. The storage is a small register array. A host drives a simple synchronous bus. Writes to the bank are command cycles that move the device between its read modes: array contents, identifier codes and a status word. Writes also start program and erase operations. Reads return data one cycle after the request, and the data returned depends on the current mode as well as on the address.

Program and erase behave the way flash cells do. A program combines the new word with the stored word by a bitwise AND, so a stored 0 bit never returns to 1. An erase sets every word of the addressed block to all ones. Each operation keeps the device busy for a fixed number of cycles, and that count is set by a parameter. Software polls the status word until the ready bit returns. While the device is busy, command writes have no effect.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the device is in array mode, every stored word reads 0xFFFFFFFF, and status shows ready with both error bits clear.
- R2: A write whose bits 7:0 are 0xFF, issued while no operation is pending, selects array mode, in which a read at word address A returns the stored word A.
- R3: The code 0x90 selects identifier mode. In this mode word 0 reads 0x00890089, word 1 reads the DEV_CODE parameter, and every other word reads 0.
- R4: The status word carries the same byte in bits 7:0 and bits 23:16, and bits 31:24 and 15:8 are zero. In that byte, bit 7 is ready (1 when idle), bit 5 is erase error, bit 4 is program error, and all other bits are 0. The code 0x70 selects status mode.
- R5: The code 0x40 makes the next write a program-data cycle. The word at that write's address becomes the old word AND the written data.
- R6: The code 0x20 followed by a write with code 0xD0 erases the block of 2^BLOCK_W words that contains the confirm address. The block's words become 0xFFFFFFFF and other blocks are unchanged.
- R7: After a program-data write or an erase confirm, exactly PROG_CYC or ERASE_CYC consecutive reads (one per cycle, starting the next cycle) show the ready bit at 0. The read after those shows it at 1.
- R8: From an erase or program setup until the next 0xFF command, reads return the status word whatever the address.
- R9: After 0x20, a write with any code other than 0xD0 aborts the erase, sets both error bits and leaves memory unchanged.
- R10: The code 0x50 clears both error bits.
- R11: Writes while busy, and unrecognised codes while idle, change neither the mode nor memory.
- R12: busRdValid is high in exactly the cycle after a cycle with busRd high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe (command or program data) |
| busRd | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data; command code in bits 7:0 |
| busRdata | output | 32 | Read data, registered |
| busRdValid | output | 1 | Read data valid, one cycle after busRd |

## Verification
The bench builds the bank with ADDR_W=5 and BLOCK_W=3, which gives four blocks of eight words. It sets PROG_CYC=4 and ERASE_CYC=12. These settings let an erase of block 0 be checked against a programmed word in block 1. They also keep each busy window short enough to poll on every cycle and count every busy read exactly. The long erase window leaves room for a command write mid-operation to check that busy writes are ignored.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_PROGRAM    = 8'h40;
  localparam logic [7:0] CMD_STATUS     = 8'h70;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;

  localparam logic [31:0] MFR_CODE = 32'h0089_0089;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_STATUS = 2'd2
  } readMode_e;

  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_ERASE_SETUP = 2'd1,
    ST_PROG_SETUP  = 2'd2,
    ST_BUSY        = 2'd3
  } cmdState_e;

  typedef struct packed {
    logic latchOp;   // capture operation address and data
    logic doErase;   // fill latched block with ones
    logic doProg;    // AND latched data into latched word
    logic abortErr;  // set both error bits
    logic clrErr;    // clear both error bits
  } strobes_t;

endpackage

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nor_flash_pkg::*;
#(
  parameter int ERASE_CYC = 12,
  parameter int PROG_CYC  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busWr,
  input  logic [7:0] cmdCode,
  output strobes_t  strb,
  output readMode_e readMode,
  output logic      busy,
  output logic      cmdIdle
);

  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  cmdState_e        stateQ, stateD;
  readMode_e        modeQ, modeD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             opEraseQ, opEraseD;

  always_comb begin
    stateD   = stateQ;
    modeD    = modeQ;
    cntD     = cntQ;
    opEraseD = opEraseQ;
    strb     = '0;
    case (stateQ)
      ST_IDLE: begin
        if (busWr) begin
          case (cmdCode)
            CMD_READ_ARRAY: modeD = MODE_ARRAY;
            CMD_IDENT:      modeD = MODE_IDENT;
            CMD_STATUS:     modeD = MODE_STATUS;
            CMD_CLEAR:      strb.clrErr = 1'b1;
            CMD_ERASE: begin
              stateD = ST_ERASE_SETUP;
              modeD  = MODE_STATUS;
            end
            CMD_PROGRAM: begin
              stateD = ST_PROG_SETUP;
              modeD  = MODE_STATUS;
            end
            default: ;
          endcase
        end
      end
      ST_ERASE_SETUP: begin
        if (busWr) begin
          if (cmdCode == CMD_CONFIRM) begin
            strb.latchOp = 1'b1;
            opEraseD     = 1'b1;
            cntD         = CNT_W'(ERASE_CYC);
            stateD       = ST_BUSY;
          end else begin
            strb.abortErr = 1'b1;
            stateD        = ST_IDLE;
          end
        end
      end
      ST_PROG_SETUP: begin
        if (busWr) begin
          strb.latchOp = 1'b1;
          opEraseD     = 1'b0;
          cntD         = CNT_W'(PROG_CYC);
          stateD       = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (cntQ == CNT_W'(1)) begin
          strb.doErase = opEraseQ;
          strb.doProg  = !opEraseQ;
          stateD       = ST_IDLE;
        end else begin
          cntD = cntQ - CNT_W'(1);
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      modeQ    <= MODE_ARRAY;
      cntQ     <= '0;
      opEraseQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      modeQ    <= modeD;
      cntQ     <= cntD;
      opEraseQ <= opEraseD;
    end
  end

  assign readMode = modeQ;
  assign busy     = (stateQ == ST_BUSY);
  assign cmdIdle  = (stateQ == ST_IDLE);

endmodule

// File: rtl/nor_flash_dp.sv
module nor_flash_dp
  import nor_flash_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          BLOCK_W  = 3,
  parameter logic [31:0] DEV_CODE = 32'h88F3_88F3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  readMode_e         readMode,
  input  logic              busy,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              eraseErr,
  output logic              progErr
);

  localparam int WORDS = 1 << ADDR_W;

  logic [ADDR_W-1:0] opAddrQ;
  logic [31:0]       opDataQ;
  logic              eraseErrQ, progErrQ;
  logic [31:0]       memRd [WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAddrQ <= '0;
      opDataQ <= '0;
    end else if (strb.latchOp) begin
      opAddrQ <= busAddr;
      opDataQ <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseErrQ <= 1'b0;
      progErrQ  <= 1'b0;
    end else if (strb.abortErr) begin
      eraseErrQ <= 1'b1;
      progErrQ  <= 1'b1;
    end else if (strb.clrErr) begin
      eraseErrQ <= 1'b0;
      progErrQ  <= 1'b0;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(w);
    logic [31:0] wordQ;
    logic        inBlock;
    assign inBlock = (opAddrQ[ADDR_W-1:BLOCK_W] == WADDR[ADDR_W-1:BLOCK_W]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordQ <= '1;
      end else if (strb.doErase && inBlock) begin
        wordQ <= '1;
      end else if (strb.doProg && (opAddrQ == WADDR)) begin
        wordQ <= wordQ & opDataQ;
      end
    end
    assign memRd[w] = wordQ;
  end

  logic [7:0]  statusByte;
  logic [31:0] statusWord, identWord, readSel;

  assign statusByte = {!busy, 1'b0, eraseErrQ, progErrQ, 4'b0000};
  assign statusWord = {8'h00, statusByte, 8'h00, statusByte};

  always_comb begin
    if (busAddr == ADDR_W'(0))      identWord = MFR_CODE;
    else if (busAddr == ADDR_W'(1)) identWord = DEV_CODE;
    else                            identWord = '0;
  end

  always_comb begin
    if (busy || readMode == MODE_STATUS) readSel = statusWord;
    else if (readMode == MODE_IDENT)     readSel = identWord;
    else                                 readSel = memRd[busAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= busRd;
      if (busRd) rdData <= readSel;
    end
  end

  assign eraseErr = eraseErrQ;
  assign progErr  = progErrQ;

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_flash_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          BLOCK_W   = 3,
  parameter int          ERASE_CYC = 12,
  parameter int          PROG_CYC  = 4,
  parameter logic [31:0] DEV_CODE  = 32'h88F3_88F3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busRdValid
);

  strobes_t  strb;
  readMode_e readMode;
  logic      busy, cmdIdle, eraseErr, progErr;

  nor_flash_ctrl #(
    .ERASE_CYC(ERASE_CYC),
    .PROG_CYC (PROG_CYC)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busWr   (busWr),
    .cmdCode (busWdata[7:0]),
    .strb    (strb),
    .readMode(readMode),
    .busy    (busy),
    .cmdIdle (cmdIdle)
  );

  nor_flash_dp #(
    .ADDR_W  (ADDR_W),
    .BLOCK_W (BLOCK_W),
    .DEV_CODE(DEV_CODE)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .readMode(readMode),
    .busy    (busy),
    .busRd   (busRd),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .rdData  (busRdata),
    .rdValid (busRdValid),
    .eraseErr(eraseErr),
    .progErr (progErr)
  );

endmodule

// File: rtl/nor_cmd_flash_chk.sv
module nor_cmd_flash_chk
  import nor_flash_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [31:0] DEV_CODE = 32'h88F3_88F3
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       rdData,
  input logic              rdValid,
  input logic              busy,
  input logic              cmdIdle,
  input readMode_e         readMode,
  input logic              eraseErr,
  input logic              progErr
);

  // R12: valid follows a read request by one cycle
  assert_rd_valid_R12: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> rdValid);
  assert_no_spurious_valid_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> !rdValid);

  // R7: a read while busy shows ready low in both halves
  assert_busy_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busy) |=> (rdData[7] == 1'b0 && rdData[23] == 1'b0));

  // R4: status word mirrored, upper bytes zero
  assert_status_mirror_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && (busy || readMode == MODE_STATUS)) |=>
      (rdData[31:16] == rdData[15:0] && rdData[15:8] == 8'h00));

  // R3: identifier reads
  assert_ident_mfr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busy && readMode == MODE_IDENT && busAddr == ADDR_W'(0)) |=>
      (rdData == MFR_CODE));
  assert_ident_dev_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busy && readMode == MODE_IDENT && busAddr == ADDR_W'(1)) |=>
      (rdData == DEV_CODE));

  // R10: clear command empties the error bits
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && cmdIdle && busWdata[7:0] == CMD_CLEAR) |=> (!eraseErr && !progErr));

  // R11: writes while busy leave the read mode alone
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busy) |=> $stable(readMode));

endmodule

bind nor_cmd_flash nor_cmd_flash_chk #(
  .ADDR_W  (ADDR_W),
  .DEV_CODE(DEV_CODE)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busWr   (busWr),
  .busRd   (busRd),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .rdData  (busRdata),
  .rdValid (busRdValid),
  .busy    (busy),
  .cmdIdle (cmdIdle),
  .readMode(readMode),
  .eraseErr(eraseErr),
  .progErr (progErr)
);

// File: tb/nor_cmd_flash_tb_top.sv
module nor_cmd_flash_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 5;
  localparam int          BLOCK_W    = 3;
  localparam int          ERASE_CYC  = 12;
  localparam int          PROG_CYC   = 4;
  localparam logic [31:0] DEV_CODE   = 32'h88F3_88F3;

  localparam logic [31:0] ST_READY = 32'h0080_0080;
  localparam logic [31:0] ST_BUSY  = 32'h0000_0000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWr = 1'b0;
  logic              busRd = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              busRdValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] expQ [$];
  string       tagQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nor_cmd_flash #(
    .ADDR_W   (ADDR_W),
    .BLOCK_W  (BLOCK_W),
    .ERASE_CYC(ERASE_CYC),
    .PROG_CYC (PROG_CYC),
    .DEV_CODE (DEV_CODE)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busRd     (busRd),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .busRdValid(busRdValid)
  );

  // Monitor: compare every returned read with the scoreboard head
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R12: valid data 0x%08h with no read pending, expected none", busRdata);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdata !== e) begin
          errors++;
          $display("FAIL %s: read 0x%08h, expected 0x%08h", t, busRdata, e);
        end
      end
    end
  end

  // All tasks start and end on a falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    busRd = 1'b1; busAddr = a;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // Poll right after the start write: n busy reads then one ready read
  task automatic poll(input int n, input string t);
    for (int i = 0; i < n; i++) rd(0, ST_BUSY, t);
    rd(0, ST_READY, t);
  endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr(a, 32'h40);
    wr(a, d);
    poll(PROG_CYC, "R7 program busy window");
    wr(0, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5, 32'hFFFF_FFFF, "R1 erased after reset");
    rd(0, 32'hFFFF_FFFF, "R1 array mode after reset");
    wr(0, 32'h70);
    rd(7, ST_READY, "R1 R4 reset status ready no errors");
    wr(0, 32'hFF);
    rd(3, 32'hFFFF_FFFF, "R2 back to array");

    // R5 program and AND semantics; R8 status persists
    wr(3, 32'h40);
    wr(3, 32'h1234_5678);
    poll(PROG_CYC, "R7 program busy window");
    rd(3, ST_READY, "R8 status after program");
    wr(0, 32'hFF);
    rd(3, 32'h1234_5678, "R5 programmed word");
    prog(3, 32'hFFFF_0000);
    rd(3, 32'h1234_0000, "R5 second program ANDs");
    prog(3, 32'hFFFF_FFFF);
    rd(3, 32'h1234_0000, "R5 ones cannot restore bits");
    prog(8, 32'h0000_A5A5);
    rd(8, 32'h0000_A5A5, "R5 word in block 1");

    // R11 unknown code ignored
    wr(0, 32'h33);
    rd(3, 32'h1234_0000, "R11 unknown code keeps array mode");

    // R3 identifier
    wr(0, 32'h90);
    rd(0, 32'h0089_0089, "R3 manufacturer code");
    rd(1, DEV_CODE, "R3 device code");
    rd(2, 32'h0000_0000, "R3 other ident word");
    wr(0, 32'hFF);

    // R6 erase block 0 with a write during busy (R11)
    wr(2, 32'h20);
    wr(2, 32'hD0);
    rd(0, ST_BUSY, "R7 erase busy first read");
    wr(0, 32'hFF);                         // busy cycle 2, must be ignored
    for (int i = 3; i <= ERASE_CYC; i++) rd(0, ST_BUSY, "R7 erase busy window");
    rd(0, ST_READY, "R7 erase ready after window");
    rd(6, ST_READY, "R11 R8 write during busy ignored, still status");
    wr(0, 32'hFF);
    rd(3, 32'hFFFF_FFFF, "R6 erased word in block");
    rd(7, 32'hFFFF_FFFF, "R6 last word of block");
    rd(8, 32'h0000_A5A5, "R6 other block untouched");

    // R9 abort
    wr(8, 32'h20);
    wr(8, 32'h70);
    rd(0, 32'h00B0_00B0, "R9 abort sets both errors");
    wr(0, 32'hFF);
    rd(8, 32'h0000_A5A5, "R9 memory unchanged by abort");

    // R10 clear
    wr(0, 32'h70);
    rd(1, 32'h00B0_00B0, "R10 errors held before clear");
    wr(0, 32'h50);
    rd(1, ST_READY, "R10 errors cleared");

    repeat (2) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d reads unanswered, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule